// File: doc/BRIEF.md
# Elastic Stall Pipeline

This block is a linear data pipeline in which every stage is built as a pair of separately enabled registers. The output half holds the item the stage presents downstream. The input half stays empty while data flows. A backward hold signal is sent from each stage to the one before it. To relax timing on that backward path, the hold signal is registered once every `STALL_SPAN` stages. The stages above such a register point therefore learn about a hold one cycle late, and they may push one more item into a stage that is already holding.

No separate skid register or bypass multiplexer absorbs that late item. The holding stage keeps its current item in the output half and captures the arriving item in its otherwise idle input half. While stalled, the pipeline is one item deeper per registered point. When the hold is released, the output-half item leaves first. The input-half item then moves into the output half, so order is kept and no item is lost or repeated. A source offers data with `src_valid` and must treat `src_hold` as a refusal. The consumer takes `snk_valid`/`snk_data` on any cycle in which it does not raise `snk_hold`.

Top module: `elastic_pipe`

## Requirements
- R1: After reset, `snk_valid` and `src_hold` are both 0.
- R2: Every accepted item leaves exactly once, in acceptance order, for any pattern of `snk_hold`. An item is accepted on a cycle with `src_valid`=1 and `src_hold`=0. An item leaves on a cycle with `snk_valid`=1 and `snk_hold`=0.
- R3: No stage ever receives an item while both of its halves are occupied and its output half is held.
- R4: While `snk_valid`=1 and `snk_hold`=1, the following cycle still shows `snk_valid`=1 with unchanged `snk_data`.
- R5: In an empty pipeline with no hold, an item accepted in cycle t appears at the output in cycle t+`DEPTH`. Back-to-back items leave one per cycle.
- R6: A value offered while `src_hold`=1 is not taken and never appears at the output.
- R7: With the pipeline full and streaming, `src_hold` rises exactly L cycles after `snk_hold` rises, where L = floor((`DEPTH`-1)/`STALL_SPAN`) is the number of registered hold points.
- R8: A full pipeline under a persistent hold contains exactly `DEPTH`+L items. Only stages directly below a registered hold point ever use their input half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | 1 | Upstream offers an item |
| src_data | input | DATA_W | Offered item |
| src_hold | output | 1 | Pipeline refuses the current offer |
| snk_valid | output | 1 | Output item present |
| snk_data | output | DATA_W | Output item |
| snk_hold | input | 1 | Consumer holds the output item |

## Verification
The risky coincidence happens at a stage just below a registered hold point. There, a late-arriving item has to be captured in the input half in the same cycle that the hold releases, the output half drains and the input-half item moves forward. The bench provokes this with bursty random holds that often toggle on consecutive cycles, while the source offers on most cycles. Each fresh offer carries a unique value, so a refused offer that slipped in would stand out. A queue scoreboard judges every departing item against acceptance order. A checker keeps count of accepted minus departed items and matches it against the occupied halves every cycle.

// File: rtl/elastic_pipe_pkg.sv
package elastic_pipe_pkg;

  // Hold from stage idx to stage idx-1 is registered on every span-th boundary.
  function automatic bit link_is_timed(int unsigned idx, int unsigned span);
    return (idx != 0) && (span != 0) && ((idx % span) == 0);
  endfunction

  function automatic int unsigned timed_links(int unsigned depth, int unsigned span);
    return (span == 0) ? 0 : (depth - 1) / span;
  endfunction

endpackage

// File: rtl/elastic_stage.sv
module elastic_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              hold_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              hold_out,
  output logic              spare_busy
);

  logic              prim_v_q, spare_v_q;
  logic [DATA_W-1:0] prim_d_q, spare_d_q;
  logic              prim_v_d, spare_v_d;
  logic [DATA_W-1:0] prim_d_d;
  logic              prim_en, spare_en;
  logic              leaving, prim_free;

  always_comb begin
    leaving   = prim_v_q & ~hold_in;
    prim_free = leaving | ~prim_v_q;
    if (prim_free) begin
      prim_v_d  = spare_v_q | in_valid;
      prim_d_d  = spare_v_q ? spare_d_q : in_data;
      prim_en   = prim_v_d;
      spare_v_d = spare_v_q & in_valid;
      spare_en  = spare_v_q & in_valid;
    end else begin
      prim_v_d  = 1'b1;
      prim_d_d  = prim_d_q;
      prim_en   = 1'b0;
      spare_v_d = spare_v_q | in_valid;
      spare_en  = in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim_v_q  <= 1'b0;
      spare_v_q <= 1'b0;
    end else begin
      prim_v_q  <= prim_v_d;
      spare_v_q <= spare_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (prim_en)  prim_d_q  <= prim_d_d;
    if (spare_en) spare_d_q <= in_data;
  end

  assign out_valid  = prim_v_q;
  assign out_data   = prim_d_q;
  assign spare_busy = spare_v_q;
  assign hold_out   = spare_v_q | (prim_v_q & hold_in);

endmodule

// File: rtl/hold_link.sv
module hold_link #(
  parameter bit TIMED = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_dn,
  output logic hold_up
);

  generate
    if (TIMED) begin : g_timed
      logic hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= hold_dn;
      end
      assign hold_up = hold_q;
    end else begin : g_direct
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign hold_up = hold_dn;
    end
  endgenerate

endmodule

// File: rtl/elastic_pipe.sv
module elastic_pipe #(
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 6,
  parameter int STALL_SPAN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_hold,
  output logic              snk_valid,
  output logic [DATA_W-1:0] snk_data,
  input  logic              snk_hold
);
  import elastic_pipe_pkg::*;

  logic [DEPTH-1:0]  stg_in_v;
  logic [DEPTH-1:0]  stg_out_v;
  logic [DEPTH-1:0]  stg_hold_in;
  logic [DEPTH-1:0]  stg_hold_out;
  logic [DEPTH-1:0]  stg_spare_v;
  logic [DATA_W-1:0] stg_in_d  [DEPTH];
  logic [DATA_W-1:0] stg_out_d [DEPTH];

  assign src_hold = stg_hold_out[0];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign stg_in_v[i] = src_valid & ~stg_hold_out[0];
        assign stg_in_d[i] = src_data;
      end else begin : g_body
        assign stg_in_v[i] = stg_out_v[i-1] & ~stg_hold_in[i-1];
        assign stg_in_d[i] = stg_out_d[i-1];
      end

      if (i == DEPTH-1) begin : g_tail
        assign stg_hold_in[i] = snk_hold;
      end else begin : g_link
        hold_link #(.TIMED(link_is_timed(i+1, STALL_SPAN))) u_link (
          .clk     (clk),
          .rst_n   (rst_n),
          .hold_dn (stg_hold_out[i+1]),
          .hold_up (stg_hold_in[i])
        );
      end

      elastic_stage #(.DATA_W(DATA_W)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (stg_in_v[i]),
        .in_data    (stg_in_d[i]),
        .hold_in    (stg_hold_in[i]),
        .out_valid  (stg_out_v[i]),
        .out_data   (stg_out_d[i]),
        .hold_out   (stg_hold_out[i]),
        .spare_busy (stg_spare_v[i])
      );
    end
  endgenerate

  assign snk_valid = stg_out_v[DEPTH-1];
  assign snk_data  = stg_out_d[DEPTH-1];

endmodule

// File: rtl/elastic_pipe_chk.sv
module elastic_pipe_chk #(
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 6,
  parameter int STALL_SPAN = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_valid,
  input logic              src_hold,
  input logic              snk_valid,
  input logic [DATA_W-1:0] snk_data,
  input logic              snk_hold,
  input logic [DEPTH-1:0]  stg_in_v,
  input logic [DEPTH-1:0]  stg_out_v,
  input logic [DEPTH-1:0]  stg_hold_in,
  input logic [DEPTH-1:0]  stg_spare_v
);
  import elastic_pipe_pkg::*;

  localparam int OCC_W = $clog2(2*DEPTH + 1) + 1;

  logic [OCC_W-1:0] occ_q;
  logic             took, gave;

  assign took = src_valid & ~src_hold;
  assign gave = snk_valid & ~snk_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_q + OCC_W'(took) - OCC_W'(gave);
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!snk_valid && !src_hold));

  assert_conserve_R2: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q == OCC_W'($countones(stg_out_v) + $countones(stg_spare_v)));

  assert_hold_output_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_valid && snk_hold) |=> (snk_valid && $stable(snk_data)));

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_chk
      assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(stg_spare_v[i] && stg_out_v[i] && stg_hold_in[i] && stg_in_v[i]));
      if (!link_is_timed(i, STALL_SPAN)) begin : g_plain
        assert_spare_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
          !stg_spare_v[i]);
      end
    end
  endgenerate

endmodule

bind elastic_pipe elastic_pipe_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .STALL_SPAN(STALL_SPAN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_valid   (src_valid),
  .src_hold    (src_hold),
  .snk_valid   (snk_valid),
  .snk_data    (snk_data),
  .snk_hold    (snk_hold),
  .stg_in_v    (stg_in_v),
  .stg_out_v   (stg_out_v),
  .stg_hold_in (stg_hold_in),
  .stg_spare_v (stg_spare_v)
);

// File: tb/elastic_pipe_bench.sv
module elastic_pipe_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int DEPTH      = 6;
  localparam int STALL_SPAN = 3;
  localparam int LINKS      = (DEPTH - 1) / STALL_SPAN;

  logic              clk, rst_n;
  logic              src_valid, src_hold, snk_valid, snk_hold;
  logic [DATA_W-1:0] src_data, snk_data;

  elastic_pipe #(.DATA_W(DATA_W), .DEPTH(DEPTH), .STALL_SPAN(STALL_SPAN)) u_elastic_pipe (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
    .src_hold(src_hold), .snk_valid(snk_valid), .snk_data(snk_data), .snk_hold(snk_hold)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int                n_checks = 0;
  int                n_fail   = 0;
  int                cyc      = 0;
  logic [DATA_W-1:0] exp_q [$];
  logic [DATA_W-1:0] offer_seq = '0;
  logic              prev_held = 1'b0;
  logic [DATA_W-1:0] prev_data = '0;
  logic              seen_hold;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle between edges, then judge the outputs that the next edge acts on.
  task automatic step(input bit vld, input bit hld, output bit acc, output bit emit);
    logic [DATA_W-1:0] exp;
    @(negedge clk);
    src_valid = vld;
    snk_hold  = hld;
    src_data  = offer_seq;
    offer_seq = offer_seq + 1'b1;
    #1;
    if (prev_held) begin
      check(snk_valid === 1'b1, "R4 valid held", longint'(snk_valid), 1);
      check(snk_data === prev_data, "R4 data held", longint'(snk_data), longint'(prev_data));
    end
    seen_hold = src_hold;
    acc  = src_valid & ~src_hold;
    emit = snk_valid & ~snk_hold;
    if (emit) begin
      if (exp_q.size() == 0) check(1'b0, "R2 unexpected item", longint'(snk_data), 0);
      else begin
        exp = exp_q.pop_front();
        check(snk_data === exp, "R2 R6 order", longint'(snk_data), longint'(exp));
      end
    end
    if (acc) exp_q.push_back(src_data);
    prev_held = snk_valid & snk_hold;
    prev_data = snk_data;
    cyc++;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL R2 watchdog actual=%0d expected=0", cyc);
    summary();
    $finish;
  end

  initial begin
    bit acc, emit, hstate;
    int acc_cyc, emit_cyc, cnt, first_hi;
    void'($urandom(32'd2718));
    rst_n = 1'b0; src_valid = 1'b0; snk_hold = 1'b0; src_data = '0;
    repeat (3) @(negedge clk);
    #1;
    check(snk_valid === 1'b0, "R1 snk_valid", longint'(snk_valid), 0);
    check(src_hold === 1'b0, "R1 src_hold", longint'(src_hold), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R5 latency of a single item
    step(1'b1, 1'b0, acc, emit);
    acc_cyc = cyc - 1;
    check(acc === 1'b1, "R5 accept", longint'(acc), 1);
    emit_cyc = -1;
    for (int k = 0; k < 3*DEPTH; k++) begin
      step(1'b0, 1'b0, acc, emit);
      if (emit && emit_cyc < 0) emit_cyc = cyc - 1;
    end
    check(emit_cyc - acc_cyc == DEPTH, "R5 latency", emit_cyc - acc_cyc, DEPTH);

    // R5 back-to-back throughput
    cnt = 0;
    for (int k = 0; k < 12 + DEPTH; k++) begin
      step(k < 12, 1'b0, acc, emit);
      if (emit) cnt++;
    end
    check(cnt == 12, "R5 throughput", cnt, 12);

    // R7 hold delay, R8 capacity, R6 refusal while held
    for (int k = 0; k < DEPTH + 4; k++) step(1'b1, 1'b0, acc, emit);
    first_hi = -1;
    for (int k = 0; k < 12; k++) begin
      step(1'b1, 1'b1, acc, emit);
      if (seen_hold && first_hi < 0) first_hi = k;
    end
    check(first_hi == LINKS, "R7 src_hold delay", first_hi, LINKS);
    check(exp_q.size() == DEPTH + LINKS, "R8 R3 held capacity", exp_q.size(), DEPTH + LINKS);
    check(seen_hold === 1'b1, "R6 refusing", longint'(seen_hold), 1);
    for (int k = 0; k < 3*DEPTH; k++) step(1'b0, 1'b0, acc, emit);
    check(exp_q.size() == 0, "R2 drained after hold", exp_q.size(), 0);

    // Alternating hold on every cycle with a full stream
    for (int k = 0; k < 200; k++) step(1'b1, k[0], acc, emit);

    // Constrained random with bursty holds
    hstate = 1'b0;
    for (int k = 0; k < 5000; k++) begin
      if ($urandom_range(0, 3) == 0) hstate = ~hstate;
      step($urandom_range(0, 9) < 7, hstate, acc, emit);
    end
    for (int k = 0; k < 4*DEPTH; k++) step(1'b0, 1'b0, acc, emit);
    check(exp_q.size() == 0, "R2 no loss", exp_q.size(), 0);
    check(snk_valid === 1'b0, "R2 no duplicate", longint'(snk_valid), 0);

    summary();
    $finish;
  end

endmodule